// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This block holds two independent 32-bit down-counters behind a small register port. Each counter has its own enable, auto-reload choice, count-source choice and prescale exponent, all held in one shared control word. A counter advances on a "counting tick". That tick is either a fabric tick strobe divided by a power of two, or an undivided fixed-reference tick strobe.

When a counter is at zero on a counting tick, it expires. It then sets a sticky event flag and, in auto-reload mode, copies its reload register into its current value. Software clears an event flag by writing a zero to that flag's bit in the status word. Each timer drives an interrupt line while its flag is set and it is enabled.

Typical uses are a free-running time base and a periodic or one-shot event source. For the time base, load 0xFFFFFFFF into both the value and reload registers, set auto-reload, and read the inverted value. For the event source, program a reload of P-1 to get an event every P ticks, or write a start value with auto-reload clear.

Top module: `dual_dtimer`

## Requirements
- R1: After a synchronous reset, every readable register reads 0 and both interrupt outputs are low.
- R2: The control word at byte address 0x00 has these fields, and they read back as written, with all other bits reading 0:
  - enable, at bit 2*i for timer i;
  - auto-reload, at bit 2*i+1;
  - fixed-reference select, at bit 11+i;
  - 3-bit prescale exponent, at bits 19+3*i upward.
- R3: The register addresses are:
  - reload of timer i at 0x10+8*i;
  - current value of timer i at 0x14+8*i.
  
  All four registers are 32-bit read/write. Read data appears on `rd_data` one cycle after `rd_en`. A value write shows one cycle later and wins over a decrement, reload or expiry in that same cycle.
- R4: With the reference select clear and exponent N, an enabled counter steps down once on every 2^N-th fabric tick, counted from the moment it is enabled. The prescaler restarts while the timer is disabled.
- R5: With the reference select set, the counter steps once per reference tick, and fabric ticks have no effect on it.
- R6: With auto-reload set and reload P-1, a timer raises an event every P counting ticks. On the expiring tick it loads the reload value, so a reload of 0xFFFFFFFF makes 0 wrap to 0xFFFFFFFF.
- R7: With auto-reload clear, the counter counts down from the written value and raises one event on the tick where it is zero. It then stays at zero with no further events until the value is rewritten.
- R8: The status word at 0x04 holds timer 0's flag at bit 0 and timer 1's flag at bit 8. Writing a 0 to a flag bit clears it, and writing a 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R9: Interrupt i equals flag i AND enable i. Clearing the enable stops the counter, which holds its value, and does not clear the flag.
- R10: The two timers are independent: activity and writes to one leave the other's value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| fab_tick | input | 1 | Fabric-clock tick strobe (one cycle per tick) |
| ref_tick | input | 1 | Fixed-reference tick strobe |
| irq | output | 2 | Per-timer interrupt, flag AND enable |

## Verification
The bench uses the default build (a 5-bit address and a 3-bit exponent) and drives the tick strobes directly, one cycle per tick. This makes every period short enough to count out tick by tick.

The bench checks the exponent over 0 to 3 and the auto-reload period over 1 to 4. Each result is compared with arithmetic expected values: the tick index of each step and the event count per window. Same-cycle collisions are forced on purpose: a value write against an expiring tick, and a clearing write against an expiry. The wrap from 0 to 0xFFFFFFFF is also checked.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int NCH   = 2;
  localparam int DW    = 32;
  localparam int PRE_W = 3;

  localparam logic [4:0] CTRL_ADDR = 5'h00;
  localparam logic [4:0] STAT_ADDR = 5'h04;

  typedef struct packed {
    logic             en;
    logic             rld;
    logic             use_ref;
    logic [PRE_W-1:0] expo;
  } tcfg_t;

  function automatic int en_pos(input int i);    return 2*i;        endfunction
  function automatic int rld_pos(input int i);   return 2*i + 1;    endfunction
  function automatic int ref_pos(input int i);   return 11 + i;     endfunction
  function automatic int exp_pos(input int i);   return 19 + 3*i;   endfunction
  function automatic int flag_pos(input int i);  return 8*i;        endfunction
  function automatic logic [4:0] rld_addr(input int i); return 5'(5'h10 + 8*i); endfunction
  function automatic logic [4:0] val_addr(input int i); return 5'(5'h14 + 8*i); endfunction
endpackage

// File: rtl/dtm_prescale.sv
module dtm_prescale #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          use_ref,
  input  logic [PW-1:0] expo,
  input  logic          fab_tick,
  input  logic          ref_tick,
  output logic          step
);
  localparam int CW = (1 << PW) - 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] lim;
  logic          fab_step;

  // 1<<expo overflows to 0 for the largest exponent; minus one gives all ones.
  assign lim      = ({{(CW-1){1'b0}}, 1'b1} << expo) - 1'b1;
  assign fab_step = fab_tick && (pcnt >= lim);
  assign step     = use_ref ? ref_tick : fab_step;

  always_ff @(posedge clk) begin
    if (rst || !en || use_ref) begin
      pcnt <= '0;
    end else if (fab_tick) begin
      pcnt <= fab_step ? '0 : pcnt + 1'b1;
    end
  end

  // R4
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pcnt == '0));

  // R5
  ref_only_chk: assert property (@(posedge clk) disable iff (rst)
    (use_ref && !ref_tick) |-> !step);
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  tcfg_t        cfg,
  input  logic         step,
  input  logic         wr_val,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         clr_wr,
  input  logic         clr_keep,
  output logic [W-1:0] value,
  output logic [W-1:0] reload,
  output logic         flag
);
  logic armed;
  logic tick_now;
  logic expire;

  assign tick_now = cfg.en && step && !wr_val;
  assign expire   = tick_now && (value == '0) && (cfg.rld || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      value  <= '0;
      reload <= '0;
      armed  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (wr_rld) reload <= wdata;
      if (wr_val) begin
        value <= wdata;
        armed <= 1'b1;
      end else if (tick_now) begin
        if (value == '0) begin
          if (cfg.rld) value <= reload;
          else         armed <= 1'b0;
        end else begin
          value <= value - 1'b1;
        end
      end
      if (expire)                 flag <= 1'b1;
      else if (clr_wr && !clr_keep) flag <= 1'b0;
    end
  end

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.en && step && !wr_val && value != '0) |=> (value == $past(value) - 1'b1));

  // R7
  one_shot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.en && step && !wr_val && value == '0 && !cfg.rld) |=> (value == '0));

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en && !wr_val) |=> $stable(value));

  // R3
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> (value == $past(wdata)));

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(value) == '0 && $past(cfg.en)));
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic              fab_tick,
  input  logic              ref_tick,
  output logic [NCH-1:0]    irq
);
  tcfg_t             cfg   [NCH];
  logic [DW-1:0]     value [NCH];
  logic [DW-1:0]     reload[NCH];
  logic [NCH-1:0]    flag;
  logic [NCH-1:0]    step;
  logic [DW-1:0]     ctrl_word;
  logic [DW-1:0]     stat_word;
  logic              ctrl_wr;
  logic              stat_wr;
  logic [4:0]        a5;

  assign a5      = 5'(addr);
  assign ctrl_wr = wr_en && (a5 == CTRL_ADDR);
  assign stat_wr = wr_en && (a5 == STAT_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= '0;
      end else if (ctrl_wr) begin
        cfg[i].en      <= wr_data[en_pos(i)];
        cfg[i].rld     <= wr_data[rld_pos(i)];
        cfg[i].use_ref <= wr_data[ref_pos(i)];
        cfg[i].expo    <= wr_data[exp_pos(i) +: PRE_W];
      end
    end

    dtm_prescale #(.PW(PRE_W)) u_pre (
      .clk      (clk),
      .rst      (rst),
      .en       (cfg[i].en),
      .use_ref  (cfg[i].use_ref),
      .expo     (cfg[i].expo),
      .fab_tick (fab_tick),
      .ref_tick (ref_tick),
      .step     (step[i])
    );

    dtm_channel #(.W(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg[i]),
      .step     (step[i]),
      .wr_val   (wr_en && (a5 == val_addr(i))),
      .wr_rld   (wr_en && (a5 == rld_addr(i))),
      .wdata    (wr_data),
      .clr_wr   (stat_wr),
      .clr_keep (wr_data[flag_pos(i)]),
      .value    (value[i]),
      .reload   (reload[i]),
      .flag     (flag[i])
    );

    assign irq[i] = flag[i] && cfg[i].en;

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg[i].en |-> !irq[i]);
  end

  always_comb begin
    ctrl_word = '0;
    stat_word = '0;
    for (int i = 0; i < NCH; i++) begin
      ctrl_word[en_pos(i)]              = cfg[i].en;
      ctrl_word[rld_pos(i)]             = cfg[i].rld;
      ctrl_word[ref_pos(i)]             = cfg[i].use_ref;
      ctrl_word[exp_pos(i) +: PRE_W]    = cfg[i].expo;
      stat_word[flag_pos(i)]            = flag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (a5 == CTRL_ADDR) rd_data <= ctrl_word;
      if (a5 == STAT_ADDR) rd_data <= stat_word;
      for (int i = 0; i < NCH; i++) begin
        if (a5 == rld_addr(i)) rd_data <= reload[i];
        if (a5 == val_addr(i)) rd_data <= value[i];
      end
    end
  end

  // R1
  rst_irq_chk: assert property (@(posedge clk) $past(rst) |-> (irq == '0));
endmodule

// File: tb/sim_dual_dtimer.sv
module sim_dual_dtimer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        fab_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_dtimer u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fab_tick(fab_tick), .ref_tick(ref_tick),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ftick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); fab_tick = 1'b1;
      @(negedge clk); fab_tick = 1'b0;
    end
  endtask

  task automatic rtick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] d;
    int ev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    foreach (u0.irq[i]) ;
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", {30'b0, irq}, 32'h0);

    // R2 control readback
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d);
    chk("R2 ctrl mask", d, 32'h01F8_180F);
    wr(5'h00, 32'h0);

    // R4 prescale sweep on timer 0
    for (int e = 0; e < 4; e++) begin
      wr(5'h14, 32'd10);
      wr(5'h00, 32'h1 | (32'(e) << 19));
      rd(5'h00, d);
      chk("R2 exp field", d, 32'h1 | (32'(e) << 19));
      ftick((3 << e) - 1);
      rd(5'h14, d);
      chk("R4 before step", d, 32'd8);
      ftick(1);
      rd(5'h14, d);
      chk("R4 on step", d, 32'd7);
      wr(5'h00, 32'h0);
    end

    // R6 auto-reload period sweep on timer 1 via reference ticks
    for (int p = 1; p <= 4; p++) begin
      wr(5'h18, 32'(p - 1));
      wr(5'h1C, 32'(p - 1));
      wr(5'h04, 32'h0);
      wr(5'h00, 32'h0000_100C);
      ev = 0;
      for (int t = 0; t < 3 * p; t++) begin
        rtick(1);
        rd(5'h04, d);
        if (d[8]) begin
          ev++;
          chk("R9 irq1 with flag", {31'b0, irq[1]}, 32'h1);
          wr(5'h04, 32'hFFFF_FEFF);
        end
      end
      chk("R6 event count", 32'(ev), 32'd3);
      rd(5'h1C, d);
      chk("R6 reloaded", d, 32'(p - 1));
      ftick(4);
      rd(5'h1C, d);
      chk("R5 fab ignored", d, 32'(p - 1));
      wr(5'h00, 32'h0);
    end

    // R6 wrap
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'h0);
    wr(5'h00, 32'h0000_100C);
    rtick(1);
    rd(5'h1C, d);
    chk("R6 wrap", d, 32'hFFFF_FFFF);
    rtick(1);
    rd(5'h1C, d);
    chk("R6 wrap next", d, 32'hFFFF_FFFE);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);

    // R7 one-shot on timer 0
    wr(5'h14, 32'd2);
    wr(5'h00, 32'h1);
    ftick(2);
    rd(5'h04, d);
    chk("R7 no early event", d, 32'h0);
    ftick(1);
    rd(5'h04, d);
    chk("R7 event", d, 32'h1);
    chk("R9 irq0", {30'b0, irq}, 32'h1);
    wr(5'h04, 32'hFFFF_FFFE);
    ftick(3);
    rd(5'h04, d);
    chk("R7 no second event", d, 32'h0);
    rd(5'h14, d);
    chk("R7 holds zero", d, 32'h0);
    wr(5'h14, 32'd1);
    ftick(2);
    rd(5'h04, d);
    chk("R7 rearmed event", d, 32'h1);

    // R8 write-one keeps
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d);
    chk("R8 one keeps", d, 32'h1);

    // R9 disable keeps flag, stops counting
    wr(5'h00, 32'h0);
    chk("R9 irq off", {30'b0, irq}, 32'h0);
    rd(5'h04, d);
    chk("R9 flag kept", d, 32'h1);
    wr(5'h14, 32'd5);
    ftick(3);
    rd(5'h14, d);
    chk("R9 holds", d, 32'd5);

    // R8 zero clears
    wr(5'h04, 32'hFFFF_FFFE);
    rd(5'h04, d);
    chk("R8 zero clears", d, 32'h0);

    // R8 expiry beats clear in same cycle
    wr(5'h14, 32'h0);
    wr(5'h00, 32'h1);
    @(negedge clk); addr = 5'h04; wr_data = 32'h0; wr_en = 1'b1; fab_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; fab_tick = 1'b0;
    rd(5'h04, d);
    chk("R8 set wins", d, 32'h1);
    wr(5'h04, 32'h0);

    // R3 value write beats expiry/reload
    wr(5'h10, 32'd9);
    wr(5'h14, 32'h0);
    wr(5'h00, 32'h3);
    @(negedge clk); addr = 5'h14; wr_data = 32'd4; wr_en = 1'b1; fab_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; fab_tick = 1'b0;
    rd(5'h14, d);
    chk("R3 write priority", d, 32'd4);
    rd(5'h04, d);
    chk("R3 no event", d, 32'h0);
    rd(5'h10, d);
    chk("R3 reload readback", d, 32'd9);

    // R10 timer 1 untouched by timer 0 activity
    rd(5'h1C, d);
    chk("R10 independent", d, 32'hFFFF_FFFE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule